// File: doc/BRIEF.md
# Freezable Performance Counter Bank

This block is a bank of event counters read and written over a simple 32-bit register bus. Slot 0 is a cycle counter, 64 bits wide by default, that advances on every clock. Each of the other slots is a 32-bit counter. It advances on the cycles where the event line picked by its 7-bit selection code is high. A global control word can freeze the whole bank at once, and each slot has its own freeze bit. The bank also raises an interrupt when a counter's top bit turns on, and it freezes itself at the same moment.

Software programs the event codes, clears the counters and then releases the freeze bits. Counting then runs until software freezes the bank again or until a counter whose condition enable is set crosses into its top bit. At that crossing the hardware sets the freeze-all bit. All counts are then held so that software can read a coherent set of values. To re-arm, software clears the top bit of the counter that overflowed and releases the freeze-all bit. Reading the lower word of the cycle counter captures its upper word, so the two halves read back as one 64-bit value.

Top module: `perf_freeze_bank`

## Requirements
- R1: After reset the global word at offset 0x40 reads 0x80000000, which means freeze-all is set and both enables are clear. Every counter and every local control word reads 0, and `irq` is low.
- R2: The global word at 0x40 holds freeze-all in bit 31, interrupt enable in bit 30 and freeze-on-condition enable in bit 29. Slot n has three words. Its local control word is at 0x50+16n, with freeze in bit 31, condition enable in bit 26 and the event code in bits 22:16. A 32-bit scratch word that reads back exactly as written is at 0x54+16n. The counter is at 0x58+16n. Read data appears on `bus_rdata` in the cycle after `bus_rd` and is 0 in every other cycle.
- R3: Slot 0 adds one on every clock while it runs, with the carry running through all 64 bits. Its upper word is written at 0x5C.
- R4: Slot n, for n from 1 up, adds one in each running cycle where `evt_in[code]` is 1, where code is the event code of slot n.
- R5: A counter runs only while both freeze-all and its own freeze bit are 0. Clearing the freeze bits resumes counting from the value that was held.
- R6: A write to a counter word takes priority over an increment in the same cycle. Writing 0 clears that word.
- R7: Reading 0x58 captures the upper word of slot 0. Reading 0x5C returns the captured word, not the live one.
- R8: The overflow condition is an increment that takes a counter's top bit from 0 to 1 while interrupt enable, freeze-on-condition enable and that slot's condition enable are all 1. On that clock edge freeze-all is set, and this overrides a software write to 0x40 in the same cycle. No counter advances after that edge.
- R9: If any one of the three enables is 0, a top-bit crossing leaves freeze-all unchanged.
- R10: `irq` is a level. It is high exactly when interrupt enable and freeze-on-condition enable are both 1 and some slot has both its condition enable set and its top bit set.
- R11: Any address that R2 does not map reads 0. Writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, registered, valid the cycle after `bus_rd` |
| evt_in | input | NEV (128) | Event pulse lines, sampled each clock |
| irq | output | 1 | Level overflow interrupt |

## Verification
The counters are driven with 128-bit event vectors drawn at random while slot freeze bits, event codes and the global freeze bit are reprogrammed at random. This separates errors in the event selection from errors in run gating, because a wrong code or a missed freeze makes a count drift from the reference. Directed patterns place a counter one or two steps below its top bit. They then clear one enable at a time, which separates a true overflow freeze from a freeze taken on a top bit that was already set or on a partial enable set. They also collide a write with an increment, and a hardware freeze with a software release, in the same cycle. A carry across the 32-bit boundary of the cycle counter, followed by split reads, shows whether the upper word is a captured value or a live one.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
   // byte offsets of the register map
   localparam int GCTL_OFS   = 32'h40;
   localparam int BANK_OFS   = 32'h50;
   localparam int SLOT_SPAN  = 16;
   // word index inside a slot (address bits 3:2)
   localparam int SUB_LCTL   = 0;
   localparam int SUB_SCR    = 1;
   localparam int SUB_CLO    = 2;
   localparam int SUB_CHI    = 3;
   // global control bit positions
   localparam int G_FRZ_ALL  = 31;
   localparam int G_IRQ_EN   = 30;
   localparam int G_COND_EN  = 29;
   // local control bit positions
   localparam int L_FRZ      = 31;
   localparam int L_COND     = 26;
   localparam int L_EVT_LSB  = 16;
   localparam int L_EVT_MAXW = 7;

   typedef struct packed {
      logic frz_all;
      logic irq_en;
      logic cond_en;
   } gctl_t;
endpackage

// File: rtl/pcb_addr_dec.sv
`timescale 1ns/1ps
module pcb_addr_dec
   import pcb_pkg::*;
#(
   parameter int AW   = 8,
   parameter int NCTR = 11
) (
   input  logic [AW-1:0]   addr,
   output logic            hit_gctl,
   output logic [NCTR-1:0] hit_slot,
   output logic [1:0]      sub
);
   localparam int SLOT_BASE = BANK_OFS / SLOT_SPAN;

   logic aligned;
   assign aligned  = (addr[1:0] == 2'b00);
   assign sub      = addr[3:2];
   assign hit_gctl = (int'(addr) == GCTL_OFS);

   for (genvar n = 0; n < NCTR; n++) begin : g_slot
      assign hit_slot[n] = aligned && (int'(addr[AW-1:4]) == SLOT_BASE + n);
   end
endmodule

// File: rtl/pcb_event_sel.sv
`timescale 1ns/1ps
module pcb_event_sel #(
   parameter int NEV = 128,
   parameter int SW  = 7
) (
   input  logic [NEV-1:0] evt,
   input  logic [SW-1:0]  sel,
   output logic           hit
);
   localparam int SPAN = 2 ** SW;

   logic [SPAN-1:0] padded;

   if (NEV >= SPAN) begin : g_trim
      assign padded = evt[SPAN-1:0];
   end else begin : g_pad
      assign padded = {{(SPAN-NEV){1'b0}}, evt};
   end

   assign hit = padded[sel];
endmodule

// File: rtl/pcb_counter.sv
`timescale 1ns/1ps
module pcb_counter #(
   parameter int W  = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic [W/DW-1:0] wr_word,
   input  logic [DW-1:0] wdata,
   output logic [W-1:0]  value,
   output logic          msb,
   output logic          msb_rise
);
   localparam int NW = W / DW;
   localparam logic [W-1:0] PRE_TOP = {1'b0, {(W-1){1'b1}}};

   logic inc;

   assign inc      = run & tick & ~(|wr_word);
   assign msb      = value[W-1];
   assign msb_rise = inc & (value == PRE_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (|wr_word) begin
         for (int k = 0; k < NW; k++) begin
            if (wr_word[k]) value[k*DW +: DW] <= wdata;
         end
      end else if (inc) begin
         value <= value + W'(1);
      end
   end
endmodule

// File: rtl/pcb_global_ctl.sv
`timescale 1ns/1ps
module pcb_global_ctl
   import pcb_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          ovf_hit,
   output gctl_t         q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.frz_all <= 1'b1;
         q.irq_en  <= 1'b0;
         q.cond_en <= 1'b0;
      end else begin
         if (wr) begin
            q.frz_all <= wdata[G_FRZ_ALL];
            q.irq_en  <= wdata[G_IRQ_EN];
            q.cond_en <= wdata[G_COND_EN];
         end
         // hardware freeze wins over a software release in the same cycle
         if (ovf_hit) q.frz_all <= 1'b1;
      end
   end
endmodule

// File: rtl/perf_freeze_bank.sv
`timescale 1ns/1ps
module perf_freeze_bank
   import pcb_pkg::*;
#(
   parameter int NCTR  = 11,
   parameter int NEV   = 128,
   parameter int EVT_W = 7,
   parameter int CYC_W = 64,
   parameter int CTR_W = 32,
   parameter int AW    = 8,
   parameter int DW    = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_wr,
   input  logic           bus_rd,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   input  logic [NEV-1:0] evt_in,
   output logic           irq
);
   localparam int CYC_NW = CYC_W / DW;

   // elaboration-time parameter checks
   if (DW != 32) begin : g_bad_dw
      $error("perf_freeze_bank: DW must be 32");
   end
   if (CYC_W != DW && CYC_W != 2*DW) begin : g_bad_cyc
      $error("perf_freeze_bank: CYC_W must be DW or 2*DW");
   end
   if (CTR_W != DW) begin : g_bad_ctr
      $error("perf_freeze_bank: CTR_W must equal DW");
   end
   if (EVT_W > L_EVT_MAXW || EVT_W < 1) begin : g_bad_evt
      $error("perf_freeze_bank: EVT_W out of range");
   end
   if (NEV > 2**EVT_W) begin : g_bad_nev
      $error("perf_freeze_bank: NEV exceeds code space");
   end
   if (BANK_OFS + SLOT_SPAN*NCTR > 2**AW) begin : g_bad_aw
      $error("perf_freeze_bank: address space too small");
   end

   logic            hit_g;
   logic [NCTR-1:0] hit_s;
   logic [1:0]      sub;
   gctl_t           gq;

   logic [NCTR-1:0] frz_v, ce_v, msb_v, rise_v, run_v, tick_v;
   logic [DW-1:0]   lctl_rd [NCTR];
   logic [DW-1:0]   scr_rd  [NCTR];
   logic [DW-1:0]   cnt_lo  [NCTR];
   logic [CYC_W-1:0] cyc_val;
   logic [DW-1:0]   snap_rd;
   logic            ovf_hit;
   logic [DW-1:0]   rd_next;
   logic            g_frz_all, g_irq_en, g_cond_en;

   pcb_addr_dec #(.AW(AW), .NCTR(NCTR)) u_dec (
      .addr     (bus_addr),
      .hit_gctl (hit_g),
      .hit_slot (hit_s),
      .sub      (sub)
   );

   pcb_global_ctl #(.DW(DW)) u_gctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr & hit_g),
      .wdata   (bus_wdata),
      .ovf_hit (ovf_hit),
      .q       (gq)
   );

   assign g_frz_all = gq.frz_all;
   assign g_irq_en  = gq.irq_en;
   assign g_cond_en = gq.cond_en;

   for (genvar n = 0; n < NCTR; n++) begin : g_slot
      logic             frz_q, ce_q;
      logic [EVT_W-1:0] sel_q;
      logic [DW-1:0]    scr_q;
      logic             lctl_wr, scr_wr;

      assign lctl_wr = bus_wr & hit_s[n] & (sub == 2'(SUB_LCTL));
      assign scr_wr  = bus_wr & hit_s[n] & (sub == 2'(SUB_SCR));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            frz_q <= 1'b0;
            ce_q  <= 1'b0;
            sel_q <= '0;
            scr_q <= '0;
         end else begin
            if (lctl_wr) begin
               frz_q <= bus_wdata[L_FRZ];
               ce_q  <= bus_wdata[L_COND];
               sel_q <= bus_wdata[L_EVT_LSB +: EVT_W];
            end
            if (scr_wr) scr_q <= bus_wdata;
         end
      end

      assign frz_v[n]   = frz_q;
      assign ce_v[n]    = ce_q;
      assign run_v[n]   = ~gq.frz_all & ~frz_q;
      assign scr_rd[n]  = scr_q;
      assign lctl_rd[n] = (DW'(frz_q) << L_FRZ) | (DW'(ce_q) << L_COND)
                        | (DW'(sel_q) << L_EVT_LSB);

      if (n == 0) begin : g_cyc
         logic [CYC_NW-1:0] wsel;
         for (genvar k = 0; k < CYC_NW; k++) begin : g_word
            assign wsel[k] = bus_wr & hit_s[0] & (sub == 2'(SUB_CLO + k));
         end
         assign tick_v[n] = 1'b1;
         pcb_counter #(.W(CYC_W), .DW(DW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_v[n]),
            .tick     (tick_v[n]),
            .wr_word  (wsel),
            .wdata    (bus_wdata),
            .value    (cyc_val),
            .msb      (msb_v[n]),
            .msb_rise (rise_v[n])
         );
         assign cnt_lo[n] = cyc_val[DW-1:0];
      end else begin : g_evt
         logic [CTR_W-1:0] val;
         logic             wsel;
         assign wsel = bus_wr & hit_s[n] & (sub == 2'(SUB_CLO));
         pcb_event_sel #(.NEV(NEV), .SW(EVT_W)) u_sel (
            .evt (evt_in),
            .sel (sel_q),
            .hit (tick_v[n])
         );
         pcb_counter #(.W(CTR_W), .DW(DW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_v[n]),
            .tick     (tick_v[n]),
            .wr_word  (wsel),
            .wdata    (bus_wdata),
            .value    (val),
            .msb      (msb_v[n]),
            .msb_rise (rise_v[n])
         );
         assign cnt_lo[n] = val;
      end
   end

   // capture of the cycle counter's upper word on a lower-word read
   if (CYC_NW > 1) begin : g_snap
      logic [DW-1:0] snap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) snap_q <= '0;
         else if (bus_rd & hit_s[0] & (sub == 2'(SUB_CLO)))
            snap_q <= cyc_val[2*DW-1:DW];
      end
      assign snap_rd = snap_q;
   end else begin : g_nosnap
      assign snap_rd = '0;
   end

   assign ovf_hit = gq.irq_en & gq.cond_en & (|(rise_v & ce_v));
   assign irq     = gq.irq_en & gq.cond_en & (|(msb_v & ce_v));

   always_comb begin
      rd_next = '0;
      if (hit_g) begin
         rd_next = (DW'(gq.frz_all) << G_FRZ_ALL) | (DW'(gq.irq_en) << G_IRQ_EN)
                 | (DW'(gq.cond_en) << G_COND_EN);
      end
      for (int n = 0; n < NCTR; n++) begin
         if (hit_s[n]) begin
            case (sub)
               2'(SUB_LCTL): rd_next = lctl_rd[n];
               2'(SUB_SCR):  rd_next = scr_rd[n];
               2'(SUB_CLO):  rd_next = cnt_lo[n];
               default:      rd_next = (n == 0) ? snap_rd : '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= bus_rd ? rd_next : '0;
   end
endmodule

// File: rtl/pcb_checker.sv
`timescale 1ns/1ps
module pcb_checker #(
   parameter int CYC_W = 64,
   parameter int DW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [DW-1:0]    bus_rdata,
   input logic             irq,
   input logic             frz_all,
   input logic             irq_en,
   input logic             ovf_hit,
   input logic             frz0,
   input logic [CYC_W-1:0] cyc_val
);
   p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);

   p_cycle_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!frz_all && !frz0 && !bus_wr) |=> cyc_val == $past(cyc_val) + CYC_W'(1));

   p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_all && !bus_wr) |=> $stable(cyc_val));

   p_freeze_on_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_hit |=> frz_all);

   p_irq_after_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_hit && !bus_wr) |=> irq);

   p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);
endmodule

bind perf_freeze_bank pcb_checker #(.CYC_W(CYC_W), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .frz_all   (g_frz_all),
   .irq_en    (g_irq_en),
   .ovf_hit   (ovf_hit),
   .frz0      (frz_v[0]),
   .cyc_val   (cyc_val)
);

// File: tb/perf_freeze_bank_tb.sv
`timescale 1ns/1ps
module perf_freeze_bank_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [127:0] evt_in = '0;
   logic         irq;

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   perf_freeze_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_in(evt_in), .irq(irq)
   );

   // reference state built from the requirements
   logic [63:0] m_cnt [11];
   bit          m_frz [11];
   bit          m_ce  [11];
   logic [6:0]  m_sel [11];
   logic [31:0] m_scr [11];
   bit          m_fac, m_ien, m_cen;
   logic [31:0] m_snap;

   task automatic model_reset();
      for (int n = 0; n < 11; n++) begin
         m_cnt[n] = '0; m_frz[n] = 0; m_ce[n] = 0; m_sel[n] = '0; m_scr[n] = '0;
      end
      m_fac = 1; m_ien = 0; m_cen = 0; m_snap = '0;
   endtask

   function automatic bit is_slot(input logic [7:0] a);
      return (a >= 8'h50) && (a[1:0] == 2'b00);
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      int n;
      if (a == 8'h40) return {m_fac, m_ien, m_cen, 29'b0};
      if (!is_slot(a)) return '0;
      n = (int'(a) - 'h50) / 16;
      case (a[3:2])
         2'd0: return {m_frz[n], 4'b0, m_ce[n], 3'b0, m_sel[n], 16'b0};
         2'd1: return m_scr[n];
         2'd2: return m_cnt[n][31:0];
         default: return (n == 0) ? m_snap : 32'h0;
      endcase
   endfunction

   function automatic bit m_irq();
      bit any = 0;
      for (int n = 0; n < 11; n++) begin
         if (m_ce[n] && (n == 0 ? m_cnt[n][63] : m_cnt[n][31])) any = 1;
      end
      return m_ien && m_cen && any;
   endfunction

   task automatic model_step(input bit w, input bit r, input logic [7:0] a,
                             input logic [31:0] d, input logic [127:0] ev);
      bit ovf = 0;
      int sn = is_slot(a) ? (int'(a) - 'h50) / 16 : -1;
      if (r && a == 8'h58) m_snap = m_cnt[0][63:32];
      for (int n = 0; n < 11; n++) begin
         bit wr_lo = w && sn == n && a[3:2] == 2'd2;
         bit wr_hi = w && sn == 0 && n == 0 && a[3:2] == 2'd3;
         bit tk = (n == 0) ? 1'b1 : ev[m_sel[n]];
         int top = (n == 0) ? 63 : 31;
         logic [63:0] old = m_cnt[n];
         if (wr_lo) m_cnt[n][31:0] = d;
         else if (wr_hi) m_cnt[n][63:32] = d;
         else if (!m_fac && !m_frz[n] && tk) begin
            m_cnt[n] = (n == 0) ? old + 64'd1 : {32'b0, old[31:0] + 32'd1};
            if (!old[top] && m_cnt[n][top] && m_ce[n] && m_ien && m_cen) ovf = 1;
         end
      end
      if (w && a == 8'h40) begin
         m_fac = d[31]; m_ien = d[30]; m_cen = d[29];
      end
      if (w && sn >= 0 && a[3:2] == 2'd0) begin
         m_frz[sn] = d[31]; m_ce[sn] = d[26]; m_sel[sn] = d[22:16];
      end
      if (w && sn >= 0 && a[3:2] == 2'd1) m_scr[sn] = d;
      if (ovf) m_fac = 1;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                      input logic [31:0] d, input logic [127:0] ev, input string tag);
      logic [31:0] exp;
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; evt_in = ev;
      exp = m_read(a);
      model_step(w, r, a, d, ev);
      @(posedge clk);
      #1;
      if (r) chk(bus_rdata, exp, tag);
      chk({31'b0, irq}, {31'b0, m_irq()}, "R10 irq level");
      bus_wr = 0; bus_rd = 0; evt_in = '0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      cyc(1, 0, a, d, '0, tag);
   endtask
   task automatic rd(input logic [7:0] a, input string tag);
      cyc(0, 1, a, 32'h0, '0, tag);
   endtask
   task automatic idle(input int k, input logic [127:0] ev);
      for (int i = 0; i < k; i++) cyc(0, 0, 8'h00, 32'h0, ev, "idle");
   endtask

   function automatic logic [127:0] rnd_ev();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   function automatic logic [7:0] slot_addr(input int n, input int word);
      return 8'(32'h50 + 16*n + 4*word);
   endfunction

   initial begin : watchdog
      #1000000;
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin : main
      logic [127:0] ev;
      logic [31:0] first;
      void'($urandom(32'd2024));
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h40, "R1 global reset");
      rd(8'h58, "R1 cycle counter reset");
      rd(slot_addr(5, 2), "R1 event counter reset");
      rd(slot_addr(7, 0), "R1 local control reset");
      chk({31'b0, irq}, 32'h0, "R1 irq low");

      // R2 layout and scratch
      wr(slot_addr(0, 1), 32'hA5A55A5A, "R2");
      rd(slot_addr(0, 1), "R2 scratch readback");
      wr(slot_addr(3, 0), 32'hFFFF_FFFF, "R2");
      rd(slot_addr(3, 0), "R2 local control fields");
      wr(slot_addr(3, 0), 32'h0, "R2");

      // R11 unmapped
      wr(8'h44, 32'hFFFFFFFF, "R11");
      wr(8'h41, 32'h00000000, "R11");
      rd(8'h44, "R11 unmapped read");
      rd(8'h40, "R11 global untouched");

      // R3 and R5: release the bank, cycle counter advances
      wr(8'h40, 32'h0, "R5");
      idle(9, '0);
      rd(8'h58, "R3 cycle count low");
      rd(8'h5C, "R7 snapshot upper");

      // R4 event selection
      wr(slot_addr(1, 0), 32'h0005_0000, "R4");
      wr(slot_addr(2, 0), 32'h007F_0000, "R4");
      for (int i = 0; i < 12; i++) begin
         ev = '0; ev[5] = i[0]; ev[127] = (i % 3 == 0); ev[6] = 1'b1;
         cyc(0, 0, 8'h00, 32'h0, ev, "R4");
      end
      rd(slot_addr(1, 2), "R4 code 5 count");
      rd(slot_addr(2, 2), "R4 code 127 count");

      // R5 local freeze holds, then resumes
      wr(slot_addr(1, 0), 32'h8005_0000, "R5");
      ev = '0; ev[5] = 1'b1;
      idle(5, ev);
      rd(slot_addr(1, 2), "R5 local freeze holds");
      wr(slot_addr(1, 0), 32'h0005_0000, "R5");
      idle(3, ev);
      rd(slot_addr(1, 2), "R5 resume from held value");

      // random phase
      for (int i = 0; i < 800; i++) begin
         int r = $urandom_range(0, 99);
         int n = $urandom_range(1, 10);
         if (r < 10)
            cyc(1, 0, slot_addr(n, 0),
                (($urandom_range(0, 3) == 0) ? 32'h8000_0000 : 32'h0) |
                (32'($urandom_range(0, 127)) << 16), rnd_ev(), "R4");
         else if (r < 20)
            cyc(0, 1, slot_addr($urandom_range(0, 10), 2), 32'h0, rnd_ev(), "R4 random read");
         else if (r < 23)
            cyc(1, 0, 8'h40, 32'($urandom_range(0, 1)) << 31, rnd_ev(), "R5");
         else
            cyc(0, 0, 8'h00, 32'h0, rnd_ev(), "R4");
      end
      wr(8'h40, 32'h0, "R5");
      for (int n = 0; n < 11; n++) rd(slot_addr(n, 2), "R4 random final count");
      rd(8'h5C, "R7 random snapshot");

      // R6 write beats increment, zero write clears
      wr(slot_addr(1, 0), 32'h0005_0000, "R6");
      ev = '0; ev[5] = 1'b1;
      cyc(1, 0, slot_addr(1, 2), 32'h0000_0100, ev, "R6");
      rd(slot_addr(1, 2), "R6 write wins");
      wr(slot_addr(1, 2), 32'h0, "R6");
      rd(slot_addr(1, 2), "R6 write zero clears");

      // R7 snapshot across a carry
      wr(8'h5C, 32'h0000_0012, "R7");
      wr(8'h58, 32'hFFFF_FFF0, "R7");
      idle(20, '0);
      rd(8'h58, "R7 low read");
      idle(3, '0);
      rd(8'h5C, "R7 captured upper 0x13");

      // R8 overflow freeze on slot 3
      for (int n = 1; n < 11; n++) wr(slot_addr(n, 0), 32'h0, "R8");
      wr(slot_addr(3, 2), 32'h7FFF_FFFE, "R8");
      wr(slot_addr(3, 0), 32'h040A_0000, "R8");
      wr(8'h40, 32'h6000_0000, "R8");
      ev = '0; ev[10] = 1'b1;
      idle(4, ev);
      rd(8'h40, "R8 freeze-all set");
      chk({31'b0, irq}, 32'h1, "R8 irq raised");
      rd(8'h58, "R8 cycle counter frozen a");
      first = bus_rdata;
      rd(8'h58, "R8 cycle counter frozen b");
      chk(bus_rdata, first, "R8 no advance while frozen");
      rd(slot_addr(3, 2), "R8 slot 3 held");
      wr(slot_addr(3, 2), 32'h0, "R10");
      wr(8'h40, 32'h6000_0000, "R8");
      chk({31'b0, irq}, 32'h0, "R10 re-armed irq low");

      // R8 hardware freeze beats same-cycle release
      wr(slot_addr(3, 2), 32'h7FFF_FFFF, "R8");
      cyc(1, 0, 8'h40, 32'h6000_0000, ev, "R8");
      rd(8'h40, "R8 hw set beats sw release");
      wr(slot_addr(3, 2), 32'h0, "R8");

      // R9 each enable missing
      wr(8'h40, 32'h4000_0000, "R9");
      wr(slot_addr(3, 2), 32'h7FFF_FFFF, "R9");
      idle(2, ev);
      rd(8'h40, "R9 no freeze without cond enable");
      wr(slot_addr(3, 2), 32'h7FFF_FFFF, "R9");
      wr(slot_addr(3, 0), 32'h000A_0000, "R9");
      wr(8'h40, 32'h6000_0000, "R9");
      idle(2, ev);
      rd(8'h40, "R9 no freeze without slot CE");

      // R10 level follows enables, no freeze on pre-set top bit
      wr(slot_addr(3, 0), 32'h040A_0000, "R10");
      chk({31'b0, irq}, 32'h1, "R10 irq on pre-set top bit");
      rd(8'h40, "R10 no freeze without crossing");
      wr(8'h40, 32'h2000_0000, "R10");
      chk({31'b0, irq}, 32'h0, "R10 irq drops with enable clear");

      // R8 on the 64-bit cycle counter
      wr(slot_addr(3, 0), 32'h0, "R8");
      wr(slot_addr(0, 0), 32'h0400_0000, "R8");
      wr(8'h5C, 32'h7FFF_FFFF, "R8");
      wr(8'h58, 32'hFFFF_FFFC, "R8");
      wr(8'h40, 32'h6000_0000, "R8");
      idle(4, '0);
      rd(8'h40, "R8 cycle counter top bit freeze");
      rd(8'h58, "R7 low after 64-bit overflow");
      rd(8'h5C, "R7 upper after 64-bit overflow");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule